// File: doc/BRIEF.md
# Register ALU with Bit-Test

This block is the combinational arithmetic and logic stage of a small register machine working on 16-bit words. It takes a destination operand and a source operand, a 2-bit mode and a 3-bit operation select. It returns a 16-bit result, a zero status flag and an illegal-operation flag in the same cycle. The register file, instruction fetch and the shifter are outside the block. The surrounding datapath writes the result back and latches the flag.

The mode selects one of three groups. In the binary group, the operation select picks add, subtract, multiply (low half), unsigned divide, AND, OR or XOR. In the one-operand group, the destination is inverted or negated. In the bit-test group, the destination bit that the source operand indexes is returned on the zero flag, and the result is the destination with that bit forced to 1 or 0. Reserved encodings produce a zero result and raise the illegal flag. They do not trap.

Top module: `reg_alu`

## Requirements
- R1: With mode 00 (binary), select 000 returns dst+src and select 001 returns dst-src, both modulo 2^16.
- R2: With mode 00, select 010 returns the low 16 bits of the unsigned product dst*src.
- R3: With mode 00 and src not zero, select 011 returns the unsigned quotient dst/src, rounded toward zero.
- R4: With mode 00, select 011 and src equal to zero, the result is 16'hFFFF and the illegal flag stays low.
- R5: With mode 00, select 100 returns dst AND src, 101 returns dst OR src, and 110 returns dst XOR src.
- R6: With mode 00 and select 111 (reserved), the result is zero, the zero flag is 1 and the illegal flag is 1.
- R7: With mode 01 (one-operand), select bit 0 equal to 0 returns ~dst and equal to 1 returns the two's-complement negation of dst. Select bits 2:1 and src have no effect.
- R8: With mode 10 (bit-test), the zero flag equals bit src[3:0] of dst. src[15:4] has no effect.
- R9: With mode 10, bit src[3:0] of the result equals select bit 0 (1 sets, 0 clears), and every other result bit equals the matching bit of dst.
- R10: In modes 00 and 01, the zero flag is 1 exactly when the result is zero.
- R11: Mode 11 (reserved) returns a zero result with the zero flag at 1 and the illegal flag at 1, for any select and operands.
- R12: The illegal flag is 0 for every mode and select combination not named in R6 or R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Group select: 00 binary, 01 one-operand, 10 bit-test, 11 reserved |
| op_i | input | 3 | Operation select; in the one-operand and bit-test groups only bit 0 is used |
| dst_i | input | 16 | Destination operand (first operand, and the word tested in bit-test mode) |
| src_i | input | 16 | Source operand (second operand, and the bit index in bit-test mode) |
| result_o | output | 16 | Computed word |
| zero_o | output | 1 | Zero status, or the tested old bit in bit-test mode |
| illegal_o | output | 1 | High for reserved encodings |

## Verification
The assertions assume that every input holds a known two-state value and stays still while the combinational outputs settle. They are evaluated as immediate checks once the inputs have been applied. The bench changes the inputs only right after a rising clock edge and compares the outputs on the falling edge, so every comparison sees settled values. The bench sweeps every mode and select code, including the reserved ones. The operands come from a fixed set of corner words (0, 1, all ones, the sign bit alone, byte masks) plus a spread of computed values. In bit-test mode the upper bits of the index are varied deliberately, to show that only the low four bits take part.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

  typedef enum logic [1:0] {
    MODE_BIN   = 2'b00,
    MODE_UNARY = 2'b01,
    MODE_BIT   = 2'b10,
    MODE_RSVD  = 2'b11
  } alu_mode_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_RSVD = 3'd7
  } bin_op_e;

endpackage

// File: rtl/reg_alu_arith.sv
module reg_alu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  // Shift-and-add product that keeps only the low WIDTH bits.
  function automatic logic [WIDTH-1:0] mul_lo(input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] acc;
    acc = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (b[i]) acc = acc + (a << i);
    end
    return acc;
  endfunction

  // Restoring unsigned division; a zero divisor saturates to all ones.
  function automatic logic [WIDTH-1:0] udiv(input logic [WIDTH-1:0] a,
                                            input logic [WIDTH-1:0] b);
    logic [WIDTH:0]   rem;
    logic [WIDTH-1:0] quo;
    rem = '0;
    quo = '0;
    if (b == '0) return '1;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      rem = {rem[WIDTH-1:0], a[i]};
      if (rem >= {1'b0, b}) begin
        rem    = rem - {1'b0, b};
        quo[i] = 1'b1;
      end
    end
    return quo;
  endfunction

  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i + b_i;
      2'b01:   res_o = a_i - b_i;
      2'b10:   res_o = mul_lo(a_i, b_i);
      default: res_o = udiv(a_i, b_i);
    endcase
  end

endmodule

// File: rtl/reg_alu_logic.sv
module reg_alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);

  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/reg_alu_unary.sv
module reg_alu_unary #(
  parameter int WIDTH = 16
) (
  input  logic             neg_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] res_o
);

  // Negation reuses the inverter and adds the select bit as the carry-in.
  function automatic logic [WIDTH-1:0] inv_plus(input logic [WIDTH-1:0] a,
                                                input logic cin);
    return (~a) + {{(WIDTH-1){1'b0}}, cin};
  endfunction

  assign res_o = inv_plus(a_i, neg_i);

endmodule

// File: rtl/reg_alu_bitop.sv
module reg_alu_bitop #(
  parameter int WIDTH = 16,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  output logic [WIDTH-1:0] res_o,
  output logic             old_o
);

  assign old_o = a_i[idx_i];

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign res_o[g] = (idx_i == IDX_W'(g)) ? set_i : a_i[g];
  end

endmodule

// File: rtl/reg_alu.sv
module reg_alu
  import reg_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       mode_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] dst_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             illegal_o
);

  localparam int IDX_W = $clog2(WIDTH);

  alu_mode_e        mode;
  bin_op_e          bop;
  logic             is_bin, is_unary, is_bit, is_rsvd;
  logic             bin_rsvd;
  logic [WIDTH-1:0] arith_res, logic_res, unary_res, bit_res, bin_res;
  logic             old_bit;

  assign mode     = alu_mode_e'(mode_i);
  assign bop      = bin_op_e'(op_i);
  assign is_bin   = (mode == MODE_BIN);
  assign is_unary = (mode == MODE_UNARY);
  assign is_bit   = (mode == MODE_BIT);
  assign is_rsvd  = (mode == MODE_RSVD);
  assign bin_rsvd = is_bin && (bop == OP_RSVD);

  reg_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .sel_i (op_i[1:0]),
    .a_i   (dst_i),
    .b_i   (src_i),
    .res_o (arith_res)
  );

  reg_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .sel_i (op_i[1:0]),
    .a_i   (dst_i),
    .b_i   (src_i),
    .res_o (logic_res)
  );

  reg_alu_unary #(.WIDTH(WIDTH)) u_unary (
    .neg_i (op_i[0]),
    .a_i   (dst_i),
    .res_o (unary_res)
  );

  reg_alu_bitop #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_bitop (
    .a_i   (dst_i),
    .idx_i (src_i[IDX_W-1:0]),
    .set_i (op_i[0]),
    .res_o (bit_res),
    .old_o (old_bit)
  );

  assign bin_res = op_i[2] ? logic_res : arith_res;

  always_comb begin
    unique case (mode)
      MODE_BIN:   result_o = bin_rsvd ? '0 : bin_res;
      MODE_UNARY: result_o = unary_res;
      MODE_BIT:   result_o = bit_res;
      default:    result_o = '0;
    endcase
  end

  assign zero_o    = is_bit ? old_bit : (result_o == '0);
  assign illegal_o = bin_rsvd || is_rsvd;

endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [1:0]       mode_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] dst_i,
  input logic [WIDTH-1:0] src_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             illegal_o,
  input logic             old_bit,
  input logic             bin_rsvd
);

  localparam int IDX_W = $clog2(WIDTH);

  logic [IDX_W-1:0] idx;
  assign idx = src_i[IDX_W-1:0];

  always_comb begin
    if (mode_i == 2'b00 && op_i == 3'd0)
      AST_ADD_INVERTS: assert (result_o - src_i == dst_i) else $error("add"); // R1
    if (mode_i == 2'b00 && op_i == 3'd3 && src_i == '0)
      AST_DIV_ZERO_ONES: assert (&result_o && !illegal_o) else $error("div0"); // R4
    if (illegal_o)
      AST_ILLEGAL_QUIET: assert (result_o == '0 && zero_o) else $error("ill"); // R6
    if (bin_rsvd)
      AST_RSVD_OP_FLAG: assert (illegal_o) else $error("rsvd op"); // R6
    if (mode_i == 2'b01 && op_i[0])
      AST_NEG_SUM_ZERO: assert (result_o + dst_i == '0) else $error("neg"); // R7
    if (mode_i == 2'b01 && !op_i[0])
      AST_NOT_DISJOINT: assert ((result_o & dst_i) == '0 && &(result_o | dst_i)) else $error("not"); // R7
    if (mode_i == 2'b10)
      AST_BIT_OLD_FLAG: assert (zero_o == old_bit && old_bit == dst_i[idx]) else $error("bitflag"); // R8
    if (mode_i == 2'b10)
      AST_BIT_NEW_VALUE: assert (result_o[idx] == op_i[0]) else $error("bitval"); // R9
    if (mode_i == 2'b10)
      AST_BIT_OTHERS_KEPT: assert ($countones(result_o ^ dst_i) <= 1) else $error("bitkeep"); // R9
    if (mode_i[1] == 1'b0)
      AST_ZERO_MATCHES: assert (zero_o == (result_o == '0)) else $error("zero"); // R10
    if (mode_i == 2'b11)
      AST_RSVD_MODE_FLAG: assert (illegal_o) else $error("rsvd mode"); // R11
    if (mode_i == 2'b01 || mode_i == 2'b10)
      AST_NO_FALSE_ILLEGAL: assert (!illegal_o) else $error("false ill"); // R12
  end

endmodule

bind reg_alu reg_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .mode_i    (mode_i),
  .op_i      (op_i),
  .dst_i     (dst_i),
  .src_i     (src_i),
  .result_o  (result_o),
  .zero_o    (zero_o),
  .illegal_o (illegal_o),
  .old_bit   (old_bit),
  .bin_rsvd  (bin_rsvd)
);

// File: tb/tb_reg_alu.sv
module tb_reg_alu;

  logic        clk = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [2:0]  op_i = '0;
  logic [15:0] dst_i = '0;
  logic [15:0] src_i = '0;
  logic [15:0] result_o;
  logic        zero_o;
  logic        illegal_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  reg_alu dut (
    .mode_i    (mode_i),
    .op_i      (op_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .result_o  (result_o),
    .zero_o    (zero_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [15:0] pat(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h8000;
      4: return 16'h7FFF;
      5: return 16'h0002;
      6: return 16'h00FF;
      7: return 16'hFF00;
      8: return 16'h0003;
      9: return 16'h0010;
      default: return 16'((k * 40503) ^ (k << 9) ^ (k >> 2));
    endcase
  endfunction

  task automatic apply_and_check(input string tag, input logic [1:0] m,
                                 input logic [2:0] o, input logic [15:0] a,
                                 input logic [15:0] b, input logic [15:0] er,
                                 input logic ez, input logic ei);
    @(posedge clk);
    mode_i = m; op_i = o; dst_i = a; src_i = b;
    @(negedge clk);
    vectors++;
    if (result_o !== er || zero_o !== ez || illegal_o !== ei) begin
      errors++;
      $display("FAIL %s mode=%b op=%b dst=%h src=%h : got res=%h z=%b ill=%b, expected res=%h z=%b ill=%b",
               tag, m, o, a, b, result_o, zero_o, illegal_o, er, ez, ei);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] a, b, e;
    logic [31:0] p;
    string tag;

    // reset-state check: all-zero inputs give an add of zero
    apply_and_check("R1 R10 reset", 2'b00, 3'd0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);

    // binary group, every select code against corner and spread operands
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 64; i++) begin
        for (int j = 0; j < 64; j++) begin
          a = pat(i); b = pat(j);
          case (op)
            0: begin e = 16'(a + b); tag = "R1 R10 R12 add"; end
            1: begin e = 16'(a - b); tag = "R1 R10 R12 sub"; end
            2: begin p = {16'h0, a} * {16'h0, b}; e = p[15:0]; tag = "R2 R10 R12 mul"; end
            3: begin
                 if (b == 0) begin e = 16'hFFFF; tag = "R4 R10 R12 div0"; end
                 else begin e = a / b; tag = "R3 R10 R12 div"; end
               end
            4: begin e = a & b; tag = "R5 R10 R12 and"; end
            5: begin e = a | b; tag = "R5 R10 R12 or"; end
            6: begin e = a ^ b; tag = "R5 R10 R12 xor"; end
            default: begin e = 16'h0; tag = "R6 reserved op"; end
          endcase
          apply_and_check(tag, 2'b00, 3'(op), a, b, e, (e == 16'h0), (op == 7));
        end
      end
    end

    // one-operand group: upper select bits and src are irrelevant
    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 64; i++) begin
        a = pat(i);
        e = (o % 2 == 1) ? 16'(0 - a) : ~a;
        apply_and_check("R7 R10 R12 unary", 2'b01, 3'(o), a, pat(63 - i), e, (e == 16'h0), 1'b0);
      end
    end

    // bit-test group: all indices, upper index bits varied
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 16; k++) begin
        for (int s = 0; s < 2; s++) begin
          for (int u = 0; u < 2; u++) begin
            a = pat(i);
            b = {(u == 1) ? pat(i + k)[15:4] : 12'h000, 4'(k)};
            e = a;
            e[k] = 1'(s);
            apply_and_check("R8 R9 R12 bittest", 2'b10, {2'(u * 3), 1'(s)}, a, b, e, a[k], 1'b0);
          end
        end
      end
    end

    // reserved mode
    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 32; i++) begin
        apply_and_check("R11 reserved mode", 2'b11, 3'(o), pat(i), pat(i + 7), 16'h0, 1'b1, 1'b1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule